// File: doc/BRIEF.md
# Three-Level PWM Input Classifier

This block sits behind the digitizer of a power-stage control input and turns a voltage sample, given in millivolts and refreshed on every clock, into one of three drive commands: drive the high side, drive the low side, or shut both sides off. A voltage near either rail selects the matching switch. A voltage that stays in the middle window long enough means the controller has released the line, for instance to shed a phase. In that case both switches are turned off.

Each band has two thresholds, one to enter it and one to leave it, so noise near a boundary does not make the command chatter. A visit to the middle window that ends before a programmable hold-off count runs out keeps the command that was in force before it. A hold-off counter that reaches its limit produces the shutdown command. An input that is left undriven settles inside the middle window, so it always ends in shutdown. When the input leaves shutdown for either outer band, the matching command is issued at once. A one-cycle flag marks that first command.

Top module: `pwm3_level_classifier`

## Requirements
- R1: While reset is held and on the first cycle after it, `cmd_o` is 2'b00 (shutdown) and `exit_o` is 0. The command encoding is 2'b00 shutdown, 2'b01 low side on, 2'b10 high side on.
- R2: From the middle window, a sample strictly greater than HI_ENTER_MV (2250 by default) gives `cmd_o` = 2'b10 after the next rising clock edge. A sample equal to HI_ENTER_MV does not enter the high band.
- R3: Once in the high band, the block stays there while samples are at or above HI_EXIT_MV (2200). A sample below it leaves the band.
- R4: From the middle window, a sample strictly below LO_ENTER_MV (850) gives `cmd_o` = 2'b01 after the next edge. A sample between LO_ENTER_MV and HI_ENTER_MV, boundaries included, keeps the band in the middle window.
- R5: Once in the low band, the block stays there while samples are at or below LO_EXIT_MV (950). A sample above it leaves the band.
- R6: `cmd_o` becomes 2'b00 on the edge that registers the HOLD_CYCLES-th consecutive middle-window sample (20 by default). A floating input of about 1600 mV therefore ends in shutdown.
- R7: While the input is in the middle window and fewer than HOLD_CYCLES consecutive samples have been taken there, the previous command is held. Any sample outside the window restarts the count.
- R8: `exit_o` is 1 for exactly the one cycle in which `cmd_o` first changes from 2'b00 to 2'b01 or 2'b10. It is 0 at all other times, including a change between low and high.
- R9: A sample in the opposite outer band moves the command directly between 2'b01 and 2'b10 on the next edge, without passing through shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; samples are taken on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | CODE_W (12) | Input voltage sample in millivolts, unsigned |
| cmd_o | output | 2 | Drive command: 00 shutdown, 01 low side, 10 high side |
| exit_o | output | 1 | One-cycle mark on the first command after shutdown |

## Verification
The assertions assume `code_i` is a settled binary value at every rising edge and holds a single sample per clock. They also assume the thresholds are ordered, with the low pair below the high pair and each exit threshold inside its entry threshold. The bench changes `code_i` only on falling edges, keeps the default threshold order, and picks sample values exactly on and one step either side of each threshold. This lets the strict and inclusive comparisons be told apart. Middle-window runs of HOLD_CYCLES-1 and of HOLD_CYCLES samples test the hold-off boundary from both sides.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_LOW  = 2'b01,
        CMD_HIGH = 2'b10
    } drive_cmd_e;

    typedef enum logic [1:0] {
        BAND_MID  = 2'b00,
        BAND_LOW  = 2'b01,
        BAND_HIGH = 2'b10
    } band_e;

endpackage

// File: rtl/pwm3_band_decode.sv
module pwm3_band_decode
    import pwm3_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int HI_ENTER_MV = 2250,
    parameter int HI_EXIT_MV  = 2200,
    parameter int LO_ENTER_MV = 850,
    parameter int LO_EXIT_MV  = 950
) (
    input  logic [CODE_W-1:0] code_i,
    input  band_e             band_q_i,
    output band_e             band_d_o
);

    localparam logic [CODE_W-1:0] HI_ENTER_C = CODE_W'(HI_ENTER_MV);
    localparam logic [CODE_W-1:0] HI_EXIT_C  = CODE_W'(HI_EXIT_MV);
    localparam logic [CODE_W-1:0] LO_ENTER_C = CODE_W'(LO_ENTER_MV);
    localparam logic [CODE_W-1:0] LO_EXIT_C  = CODE_W'(LO_EXIT_MV);

    logic over_hi_enter;
    logic under_hi_exit;
    logic under_lo_enter;
    logic over_lo_exit;

    always_comb begin
        over_hi_enter  = code_i > HI_ENTER_C;
        under_hi_exit  = code_i < HI_EXIT_C;
        under_lo_enter = code_i < LO_ENTER_C;
        over_lo_exit   = code_i > LO_EXIT_C;

        band_d_o = band_q_i;
        unique case (band_q_i)
            BAND_HIGH: begin
                if (under_lo_enter)     band_d_o = BAND_LOW;
                else if (under_hi_exit) band_d_o = BAND_MID;
            end
            BAND_LOW: begin
                if (over_hi_enter)      band_d_o = BAND_HIGH;
                else if (over_lo_exit)  band_d_o = BAND_MID;
            end
            default: begin
                if (over_hi_enter)       band_d_o = BAND_HIGH;
                else if (under_lo_enter) band_d_o = BAND_LOW;
                else                     band_d_o = BAND_MID;
            end
        endcase
    end

endmodule

// File: rtl/pwm3_holdoff.sv
module pwm3_holdoff #(
    parameter int HOLD_CYCLES = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mid_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mid_i)
            st_d.cnt = '0;
        else if (st_q.cnt != LIMIT)
            st_d.cnt = st_q.cnt + 1'b1;
        expired_o = mid_i && (st_d.cnt == LIMIT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R7: leaving the window restarts the count
    assert_count_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mid_i |=> (st_q.cnt == '0));

    // R6: the count never passes its limit
    assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LIMIT);

endmodule

// File: rtl/pwm3_level_classifier.sv
module pwm3_level_classifier
    import pwm3_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int HI_ENTER_MV = 2250,
    parameter int HI_EXIT_MV  = 2200,
    parameter int LO_ENTER_MV = 850,
    parameter int LO_EXIT_MV  = 950,
    parameter int HOLD_CYCLES = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    output logic [1:0]        cmd_o,
    output logic              exit_o
);

    localparam logic [CODE_W-1:0] HI_EXIT_C = CODE_W'(HI_EXIT_MV);
    localparam logic [CODE_W-1:0] LO_EXIT_C = CODE_W'(LO_EXIT_MV);

    typedef struct packed {
        band_e      band;
        drive_cmd_e cmd;
        logic       leave;
    } cls_st_t;

    cls_st_t st_d, st_q;
    band_e   band_next;
    logic    hold_expired;

    pwm3_band_decode #(
        .CODE_W      (CODE_W),
        .HI_ENTER_MV (HI_ENTER_MV),
        .HI_EXIT_MV  (HI_EXIT_MV),
        .LO_ENTER_MV (LO_ENTER_MV),
        .LO_EXIT_MV  (LO_EXIT_MV)
    ) band_dec_i (
        .code_i   (code_i),
        .band_q_i (st_q.band),
        .band_d_o (band_next)
    );

    pwm3_holdoff #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) holdoff_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mid_i     (band_next == BAND_MID),
        .expired_o (hold_expired)
    );

    always_comb begin
        st_d      = st_q;
        st_d.band = band_next;
        unique case (band_next)
            BAND_HIGH: st_d.cmd = CMD_HIGH;
            BAND_LOW:  st_d.cmd = CMD_LOW;
            default:   if (hold_expired) st_d.cmd = CMD_OFF;
        endcase
        st_d.leave = (st_q.cmd == CMD_OFF) && (st_d.cmd != CMD_OFF);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.band  <= BAND_MID;
            st_q.cmd   <= CMD_OFF;
            st_q.leave <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign exit_o = st_q.leave;

    // R3: the high band is only held by samples at or above its exit level
    assert_high_band_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.band == BAND_HIGH) |-> ($past(code_i) >= HI_EXIT_C));

    // R5: the low band is only held by samples at or below its exit level
    assert_low_band_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.band == BAND_LOW) |-> ($past(code_i) <= LO_EXIT_C));

    // R6: shutdown is only entered from the middle window
    assert_off_from_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd_o == CMD_OFF) && ($past(cmd_o) != CMD_OFF)) |-> (st_q.band == BAND_MID));

    // R8: the exit mark accompanies the first command after shutdown
    assert_exit_mark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exit_o |-> ((cmd_o != CMD_OFF) && ($past(cmd_o) == CMD_OFF)));

    // R1: only the three defined command codes appear
    assert_cmd_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o != 2'b11);

endmodule

// File: tb/pwm3_level_classifier_tb_top.sv
module pwm3_level_classifier_tb_top;

    localparam int CODE_W = 12;
    localparam int HOLD   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] code = 12'd1600;
    logic [1:0]        cmd;
    logic              ex;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] exp_cmd_q[$];
    logic       exp_ex_q[$];
    string      tag_q[$];

    int         m_band = 0;   // 0 middle, 1 low, 2 high
    int         m_cnt = 0;
    logic [1:0] m_cmd = 2'b00;

    always #2.5 clk = ~clk;

    pwm3_level_classifier #(.CODE_W(CODE_W), .HOLD_CYCLES(HOLD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .code_i(code), .cmd_o(cmd), .exit_o(ex)
    );

    task automatic step(input int mv, input string tag);
        int         nb;
        logic [1:0] nc;
        @(negedge clk);
        code = CODE_W'(mv);
        nb = m_band;
        if (m_band == 2) begin
            if (mv < 850) nb = 1; else if (mv < 2200) nb = 0;
        end else if (m_band == 1) begin
            if (mv > 2250) nb = 2; else if (mv > 950) nb = 0;
        end else begin
            if (mv > 2250) nb = 2; else if (mv < 850) nb = 1; else nb = 0;
        end
        nc = m_cmd;
        if (nb == 0) begin
            if (m_cnt < HOLD) m_cnt++;
            if (m_cnt >= HOLD) nc = 2'b00;
        end else begin
            m_cnt = 0;
            nc = (nb == 2) ? 2'b10 : 2'b01;
        end
        exp_cmd_q.push_back(nc);
        exp_ex_q.push_back((m_cmd == 2'b00) && (nc != 2'b00));
        tag_q.push_back(tag);
        m_band = nb;
        m_cmd  = nc;
    endtask

    task automatic run(input int mv, input int n, input string tag);
        for (int i = 0; i < n; i++) step(mv, tag);
    endtask

    // monitor: compare each registered result with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_cmd_q.size() > 0) begin
                logic [1:0] ec;
                logic       ee;
                string      t;
                ec = exp_cmd_q.pop_front();
                ee = exp_ex_q.pop_front();
                t  = tag_q.pop_front();
                checks++;
                if (cmd !== ec || ex !== ee) begin
                    errors++;
                    $display("FAIL %s cmd=%b exit=%b expected cmd=%b exit=%b",
                             t, cmd, ex, ec, ee);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (cmd !== 2'b00 || ex !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset cmd=%b exit=%b expected cmd=00 exit=0", cmd, ex);
        end
        @(negedge clk);
        rst_n = 1'b1;
        run(1600, 3, "R1");
        // R2: boundary value stays in the window, one step above enters high
        run(2250, 2, "R2");
        run(2251, 3, "R2");
        // R3: between exit and entry levels high is kept; exactly on exit too
        run(2220, 25, "R3");
        run(2200, 3, "R3");
        // R7: short excursion below the high exit keeps HIGH
        run(2199, HOLD - 1, "R7");
        run(3000, 2, "R7");
        // R7: count restarts after an outside sample
        run(1500, HOLD - 1, "R7");
        run(2600, 1, "R7");
        run(1500, HOLD - 1, "R7");
        // R6: exactly HOLD samples give shutdown
        run(1500, 1, "R6");
        run(1600, 10, "R6");
        // R4: 850 stays in window, 849 enters low, with exit mark (R8)
        run(850, 2, "R4");
        run(849, 1, "R8");
        run(700, 2, "R4");
        // R5: at and below the low exit level low is kept
        run(950, 25, "R5");
        run(930, 2, "R5");
        run(951, 3, "R5");
        // R9: direct low to high and back, no exit mark
        run(100, 2, "R9");
        run(4000, 2, "R9");
        run(0, 2, "R9");
        // R6: floating level ends in shutdown, then high exit with mark
        run(1600, HOLD + 3, "R6");
        run(2800, 2, "R8");
        run(1600, HOLD + 2, "R6");
        run(10, 2, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule